// File: doc/BRIEF.md
# UART Receive Buffer with Trigger-Level and Time-Out Interrupts

This block holds received characters for one channel of a 16550-style UART. The bit-level receiver hands it one character at a time, with its parity, framing and break flags. The host takes characters from the head of the queue. With buffering turned on, the queue holds up to `DEPTH` characters (16 by default). With buffering turned off, it holds a single character.

The block raises a data-available interrupt once the fill level reaches a programmable threshold. It raises a time-out interrupt when characters sit in the queue and no new character has arrived for four character times. It also drives a DMA request line and a data-ready status bit. All timing is counted in pulses of `rx_tick`, the 16x oversampling enable of the receiver.

Configuration comes from a write-only control byte. Bit 0 enables buffering. Bit 1 empties the receive queue. Bit 2 is the transmit-side clear, which has no effect on this block. Bit 3 selects the DMA request mode. Bits 7:6 choose the threshold. The character format comes from the line-control fields.

Both data edges use valid/ready handshakes. A character is accepted on a clock edge where `in_valid` and `in_ready` are both high. The source must hold its character until then. `in_ready` is low when the queue is at capacity, and it is also low in any cycle where `fcr_wr` is high. On the read side, a character is removed on an edge where `out_valid` and `out_ready` are both high. `out_data` and the flag outputs always show the head of the queue.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the fill level is 0. After reset `data_ready`, `rda_irq`, `timeout_irq`, `rx_dma_req` and `out_valid` are 0, and `in_ready` is 1. Buffering is off after reset.
- R2: With buffering on, up to 16 characters are held. They leave in arrival order, each with its own perr/ferr/brk flags. At 16 characters `in_ready` is 0.
- R3: With control bit 0 clear, exactly one character is held, and `in_ready` is 0 while it is held. `rda_irq` follows `data_ready` in the same cycle. `timeout_irq` never asserts.
- R4: A control write with bit 1 set empties the queue. So does a write that changes bit 0. A write that sets only bit 2 leaves the fill level unchanged.
- R5: Threshold codes in bits 7:6 are 00 for 1 character, 01 for 4, 10 for 8 and 11 for 14.
- R6: With buffering on, `rda_irq` rises on the third `rx_tick` edge after the fill reaches the threshold. It falls in the cycle after a read that takes the fill below the threshold.
- R7: The time-out fires after 4 × bits × 16 + 8 `rx_tick` edges without traffic, where bits = 1 + (5 + `lcr_wlen`) + `lcr_par_en` + (2 if `lcr_stop2` else 1). This gives 456 ticks for 5N1 and 776 ticks for 8-bit, parity, two stop bits.
- R8: Each accepted character and each host read restarts the time-out count. A host read removes a pending time-out.
- R9: `data_ready` is 1 exactly when the fill level is non-zero.
- R10: With buffering on and control bit 3 set, `rx_dma_req` rises with `rda_irq` or `timeout_irq` and stays high until the queue is empty. In every other mode, `rx_dma_req` equals `data_ready`.
- R11: `fill_level` reports the number of characters held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_tick | input | 1 | 16x receiver clock enable |
| in_valid | input | 1 | Character offered by the receiver |
| in_ready | output | 1 | Character can be accepted |
| in_data | input | 8 | Received character |
| in_perr | input | 1 | Parity error flag |
| in_ferr | input | 1 | Framing error flag |
| in_brk | input | 1 | Break flag |
| out_valid | output | 1 | Head character present |
| out_ready | input | 1 | Host reads the head |
| out_data | output | 8 | Head character |
| out_perr | output | 1 | Head parity error flag |
| out_ferr | output | 1 | Head framing error flag |
| out_brk | output | 1 | Head break flag |
| fcr_wr | input | 1 | Control byte write strobe |
| fcr_data | input | 8 | Control byte |
| lcr_wlen | input | 2 | Data bits minus 5 |
| lcr_par_en | input | 1 | Parity bit present |
| lcr_stop2 | input | 1 | Two stop bits |
| fill_level | output | 5 | Characters held |
| data_ready | output | 1 | At least one character held |
| rda_irq | output | 1 | Threshold interrupt |
| timeout_irq | output | 1 | Character time-out interrupt |
| rx_dma_req | output | 1 | DMA request |

## Verification
The following outputs react combinationally in the cycle after the accepting or reading edge, so the bench samples them at the next falling edge: the fill level, `data_ready`, `in_ready`, a cleared `rda_irq`, and the mode-0 DMA request. The rising `rda_irq` and `timeout_irq` are due on a counted `rx_tick` edge: the third, or the 456th or 776th, after the event that armed them. The bench drives `rx_tick` itself and counts only the edges where the tick is high. It checks one tick early for absence and on the due tick for presence. Control-write effects appear in the cycle after the write edge.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  // threshold code to character count, scaled to the queue depth
  function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // serial bits per character: start + data + parity + stop
  function automatic int unsigned frame_bits(input logic [1:0] wlen, input logic par_en,
                                             input logic stop2);
    return 32'd6 + 32'(wlen) + 32'(par_en) + (stop2 ? 32'd2 : 32'd1);
  endfunction
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fcr_wr,
  input  logic [7:0] fcr_data,
  output logic       fifo_en,
  output logic       dma_mode,
  output logic [1:0] trig_code,
  output logic       clr
);
  localparam int EN_BIT  = 0;
  localparam int CLR_BIT = 1;
  localparam int DMA_BIT = 3;
  localparam int TRG_LSB = 6;

  // a clear happens on an explicit request or on any change of the enable
  assign clr = fcr_wr && (fcr_data[CLR_BIT] || (fcr_data[EN_BIT] != fifo_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      dma_mode  <= 1'b0;
      trig_code <= 2'b00;
    end else if (fcr_wr) begin
      fifo_en <= fcr_data[EN_BIT];
      if (fcr_data[EN_BIT]) begin
        dma_mode  <= fcr_data[DMA_BIT];
        trig_code <= fcr_data[TRG_LSB+1:TRG_LSB];
      end
    end
  end

  p_clr_on_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && (fcr_data[EN_BIT] != fifo_en) |=> (fifo_en == $past(fcr_data[EN_BIT])));
endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             single,
  input  logic             in_valid,
  output logic             in_ready,
  input  rx_char_t         in_char,
  output logic             out_valid,
  input  logic             out_ready,
  output rx_char_t         out_char,
  output logic             push,
  output logic             pop,
  output logic [CNT_W-1:0] count
);
  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cap;

  assign cap       = single ? CNT_W'(1) : CNT_W'(DEPTH);
  assign in_ready  = !hold && (count < cap);
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_char  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !in_ready);
  p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  p_single_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    single && !clr && (count != '0) && !pop |=> (count == $past(count)));
endmodule

// File: rtl/rxb_timeout.sv
module rxb_timeout
  import uart_rxb_pkg::*;
#(
  parameter int TO_CHARS  = 4,
  parameter int TICKS_BIT = 16,
  parameter int TO_LAT    = 8,
  localparam int MAX_LIM  = TO_CHARS * 12 * TICKS_BIT + TO_LAT,
  localparam int LIM_W    = $clog2(MAX_LIM + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fifo_en,
  input  logic       nonempty,
  input  logic       activity,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       stop2,
  output logic       to_irq
);
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt;

  always_comb begin
    int unsigned lim_i;
    lim_i = TO_CHARS * TICKS_BIT * frame_bits(wlen, par_en, stop2) + TO_LAT;
    limit = LIM_W'(lim_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt <= '0;
    else if (!fifo_en || !nonempty || activity) cnt <= '0;
    else if (tick && (cnt < limit))           cnt <= cnt + 1'b1;
  end

  assign to_irq = fifo_en && nonempty && (cnt >= limit);

  p_read_drops_to_r8: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !to_irq);
  p_to_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_irq) && $stable(limit) && $stable(fifo_en) |-> $past(tick));
endmodule

// File: rtl/rxb_irq.sv
module rxb_irq
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TRIG_LAT = 3,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int LAT_W   = $clog2(TRIG_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic [1:0]       trig_code,
  input  logic [CNT_W-1:0] count,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic             cfg_wr,
  input  logic             to_irq,
  output logic             rda_irq,
  output logic             rxrdy
);
  logic [CNT_W-1:0] lvl;
  logic             at_trig;
  logic [LAT_W-1:0] lat_cnt;
  logic             held;
  logic             nonempty;

  assign lvl      = CNT_W'(trig_level(trig_code, DEPTH));
  assign at_trig  = fifo_en && (count >= lvl);
  assign nonempty = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      lat_cnt <= '0;
    else if (!at_trig)                               lat_cnt <= '0;
    else if (tick && (lat_cnt < LAT_W'(TRIG_LAT)))   lat_cnt <= lat_cnt + 1'b1;
  end

  assign rda_irq = fifo_en ? (at_trig && (lat_cnt == LAT_W'(TRIG_LAT))) : nonempty;

  // block-mode request latches on an interrupt and stays until empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= !clr && nonempty && (held || rda_irq || to_irq);
  end

  assign rxrdy = (fifo_en && dma_mode) ? (nonempty && (held || rda_irq || to_irq)) : nonempty;

  p_rda_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rda_irq && pop && !push && !cfg_wr && (count == lvl) |=> !rda_irq);
  p_rxrdy_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !rxrdy);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TRIG_LAT  = 3,
  parameter int TO_CHARS  = 4,
  parameter int TICKS_BIT = 16,
  parameter int TO_LAT    = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              in_brk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_brk,
  input  logic              fcr_wr,
  input  logic [7:0]        fcr_data,
  input  logic [1:0]        lcr_wlen,
  input  logic              lcr_par_en,
  input  logic              lcr_stop2,
  output logic [CNT_W-1:0]  fill_level,
  output logic              data_ready,
  output logic              rda_irq,
  output logic              timeout_irq,
  output logic              rx_dma_req
);
  logic       fifo_en, dma_mode, clr, push, pop;
  logic [1:0] trig_code;
  rx_char_t   in_char, head;

  assign in_char = '{brk: in_brk, ferr: in_ferr, perr: in_perr, data: in_data};

  rxb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_code(trig_code), .clr(clr)
  );

  rxb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hold(fcr_wr), .single(!fifo_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(head),
    .push(push), .pop(pop), .count(fill_level)
  );

  rxb_timeout #(.TO_CHARS(TO_CHARS), .TICKS_BIT(TICKS_BIT), .TO_LAT(TO_LAT)) u_to (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .fifo_en(fifo_en),
    .nonempty(fill_level != '0), .activity(push || pop || clr),
    .wlen(lcr_wlen), .par_en(lcr_par_en), .stop2(lcr_stop2), .to_irq(timeout_irq)
  );

  rxb_irq #(.DEPTH(DEPTH), .TRIG_LAT(TRIG_LAT)) u_irq (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .trig_code(trig_code), .count(fill_level), .push(push), .pop(pop), .clr(clr),
    .cfg_wr(fcr_wr), .to_irq(timeout_irq), .rda_irq(rda_irq), .rxrdy(rx_dma_req)
  );

  assign out_data   = head.data;
  assign out_perr   = head.perr;
  assign out_ferr   = head.ferr;
  assign out_brk    = head.brk;
  assign data_ready = out_valid;

  p_push_sets_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> data_ready);
  p_off_no_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && !fcr_data[0] |=> !timeout_irq);
endmodule

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick = 1'b0;
  logic       in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_data = '0;
  logic [1:0] lcr_wlen = 2'd0;
  logic       lcr_par_en = 1'b0, lcr_stop2 = 1'b0;
  logic       in_ready, out_valid, out_perr, out_ferr, out_brk;
  logic [7:0] out_data;
  logic [4:0] fill_level;
  logic       data_ready, rda_irq, timeout_irq, rx_dma_req;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;

  always #2 clk = ~clk;

  // tick generator: high for one cycle out of four, changed away from the rising edge
  always @(negedge clk) begin
    tcnt    <= (tcnt == 3) ? 0 : tcnt + 1;
    rx_tick <= (tcnt == 3);
  end

  uart_rx_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk),
    .fcr_wr(fcr_wr), .fcr_data(fcr_data), .lcr_wlen(lcr_wlen),
    .lcr_par_en(lcr_par_en), .lcr_stop2(lcr_stop2), .fill_level(fill_level),
    .data_ready(data_ready), .rda_irq(rda_irq), .timeout_irq(timeout_irq),
    .rx_dma_req(rx_dma_req)
  );

  // table rows: [7:6] threshold code, [5:1] characters pushed, [0] rda expected
  localparam int NV = 7;
  localparam logic [7:0] VEC [NV] = '{
    {2'b00, 5'd1, 1'b1}, {2'b01, 5'd3, 1'b0}, {2'b01, 5'd4, 1'b1},
    {2'b10, 5'd7, 1'b0}, {2'b10, 5'd8, 1'b1}, {2'b11, 5'd13, 1'b0},
    {2'b11, 5'd14, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fcr_write(input logic [7:0] v);
    @(negedge clk);
    fcr_wr = 1'b1; fcr_data = v;
    @(posedge clk);
    @(negedge clk);
    fcr_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic fe, input logic bk);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_perr = pe; in_ferr = fe; in_brk = bk;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(output logic [10:0] got);
    @(negedge clk);
    got = {out_brk, out_ferr, out_perr, out_data};
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (rx_tick) k++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] got;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fill", int'(fill_level), 0);
    check("R1 data_ready", int'(data_ready), 0);
    check("R1 irqs", int'({rda_irq, timeout_irq, rx_dma_req, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", int'(in_ready), 1);

    // R5 R6 table walk: threshold codes against fill
    for (int i = 0; i < NV; i++) begin
      fcr_write({VEC[i][7:6], 6'b000011});
      for (int j = 0; j < int'(VEC[i][5:1]); j++) push(8'(j), 1'b0, 1'b0, 1'b0);
      wait_ticks(3);
      check("R5 R6 rda vs threshold", int'(rda_irq), int'(VEC[i][0]));
      check("R11 fill level", int'(fill_level), int'(VEC[i][5:1]));
    end

    // R2 order, flags, full stall
    fcr_write(8'h03);
    for (int i = 0; i < 16; i++) push(8'(i * 17 + 3), i[0], i[1], i == 5);
    check("R2 in_ready at full", int'(in_ready), 0);
    check("R2 fill at full", int'(fill_level), 16);
    for (int i = 0; i < 16; i++) begin
      pop(got);
      check("R2 order and flags", int'(got), int'({i == 5, i[1], i[0], 8'(i * 17 + 3)}));
    end
    check("R9 data_ready after drain", int'(data_ready), 0);

    // R6 latency and clear
    fcr_write(8'h43);
    for (int i = 0; i < 4; i++) push(8'hA0, 1'b0, 1'b0, 1'b0);
    wait_ticks(2);
    check("R6 rda not yet", int'(rda_irq), 0);
    wait_ticks(1);
    check("R6 rda on third tick", int'(rda_irq), 1);
    pop(got);
    check("R6 rda cleared below threshold", int'(rda_irq), 0);

    // R7 R8 time-out, 5N1: 456 ticks
    fcr_write(8'hC3);
    push(8'h11, 1'b0, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0, 1'b0);
    check("R9 data_ready after push", int'(data_ready), 1);
    wait_ticks(455);
    check("R7 no time-out early", int'(timeout_irq), 0);
    wait_ticks(1);
    check("R7 time-out due", int'(timeout_irq), 1);
    pop(got);
    check("R8 read drops time-out", int'(timeout_irq), 0);
    wait_ticks(455);
    check("R8 restart after read early", int'(timeout_irq), 0);
    wait_ticks(1);
    check("R8 restart after read due", int'(timeout_irq), 1);

    // R7 R8 time-out, 8 bits parity 2 stop: 776 ticks, restarted by a push
    lcr_wlen = 2'd3; lcr_par_en = 1'b1; lcr_stop2 = 1'b1;
    fcr_write(8'hC3);
    push(8'h33, 1'b0, 1'b0, 1'b0);
    wait_ticks(300);
    push(8'h44, 1'b0, 1'b0, 1'b0);
    wait_ticks(775);
    check("R8 push restarts count", int'(timeout_irq), 0);
    wait_ticks(1);
    check("R7 long format due", int'(timeout_irq), 1);
    lcr_wlen = 2'd0; lcr_par_en = 1'b0; lcr_stop2 = 1'b0;

    // R3 buffering off
    fcr_write(8'h00);
    check("R4 toggle clears", int'(fill_level), 0);
    push(8'h5A, 1'b1, 1'b0, 1'b0);
    check("R3 single hold stall", int'(in_ready), 0);
    check("R3 rda follows data_ready", int'(rda_irq), 1);
    wait_ticks(500);
    check("R3 no time-out", int'(timeout_irq), 0);
    pop(got);
    check("R3 held char", int'(got), int'(11'h15A));

    // R4 clear controls
    fcr_write(8'h01);
    for (int i = 0; i < 3; i++) push(8'h70, 1'b0, 1'b0, 1'b0);
    fcr_write(8'h05);
    check("R4 bit2 no effect", int'(fill_level), 3);
    fcr_write(8'h03);
    check("R4 bit1 clears", int'(fill_level), 0);

    // R10 DMA request modes
    fcr_write(8'h4B);
    push(8'h01, 1'b0, 1'b0, 1'b0);
    check("R10 block mode idle below threshold", int'(rx_dma_req), 0);
    for (int i = 0; i < 3; i++) push(8'h02, 1'b0, 1'b0, 1'b0);
    wait_ticks(3);
    check("R10 block mode request", int'(rx_dma_req), 1);
    for (int i = 0; i < 3; i++) pop(got);
    check("R10 request held until empty", int'(rx_dma_req), 1);
    pop(got);
    check("R10 request drops when empty", int'(rx_dma_req), 0);
    fcr_write(8'h03);
    push(8'h03, 1'b0, 1'b0, 1'b0);
    check("R10 single mode follows data", int'(rx_dma_req), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule